// File: doc/BRIEF.md
# Serial Flash Word Reader

This peripheral sits on a simple strobe-based processor IO bus and fetches one 32-bit word from an external serial flash chip. Software writes a flash byte address to the device. That single write starts a complete serial transaction. The block pulls chip select low and clocks out a standard single-bit read opcode followed by a 24-bit address. It then clocks in four data bytes and stores the assembled word in a holding register.

The device claims bus cycles through one bit of the IO word address, with no full address compare. A read of the device returns the held word at once. When the device is not selected, the read data is forced to zero, so the outputs of several devices can be ORed onto one return bus. Wait states exist only on the write side. The write-busy output stays high while the serial transfer runs, so software stalls only on the write that starts a fetch or on a write that follows it.

Top module: `sflash_word_reader`

## Requirements
- R1: A synchronous active-high reset, applied at any time including in the middle of a transfer, drives `spi_cs_n` high, `spi_sck` low and `io_wbusy` low, and clears the held word, so a selected read returns 0.
- R2: A write strobe with IO word address bit `SEL_BIT` (default 3) high starts a transaction; a write strobe with that bit low starts nothing (chip select stays high and busy stays low).
- R3: The first 32 bits sent on `spi_mosi` are the read opcode 0x03 followed by bits [23:0] of the written word, most significant bit first; bits [31:24] of the written word have no effect.
- R4: The serial clock idles low; `spi_mosi` changes only on a falling edge of `spi_sck` or when chip select falls; `spi_miso` is sampled at each rising edge.
- R5: Each half period of `spi_sck` lasts `DIV_HALF` system clocks (default 1, divide-by-2); chip select falls `DIV_HALF` clocks before the first rising edge; exactly 64 clock pulses follow; chip select rises `DIV_HALF` clocks after the last falling edge.
- R6: `io_wbusy` rises in the clock after the starting write and stays high for exactly 129*`DIV_HALF` clocks, covering the whole address and data phase; it then falls, in the same clock in which chip select rises.
- R7: Exactly 32 bits are received, each byte most significant bit first; the first received byte lands in bits [7:0] of the held word and the fourth in bits [31:24].
- R8: While bit `SEL_BIT` of the IO word address is high, `io_rdata` shows the held word in the same cycle with no wait; while that bit is low, `io_rdata` is all zeros.
- R9: A write arriving while busy is ignored: the running transfer keeps its address and no second transfer follows; the held word keeps its old value until the running transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wstrb | input | 1 | IO write strobe |
| io_word_addr | input | ADDR_BITS | IO word address; bit SEL_BIT selects this device |
| io_wdata | input | 32 | IO write data; bits [23:0] are the flash byte address |
| io_rdata | output | 32 | Held word when selected, zero otherwise |
| io_wbusy | output | 1 | Write wait request, high during a transfer |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Random flash addresses, with random upper bytes and random unrelated address bits, check that only the low 24 bits reach the wire and that the word is assembled in the stated byte order. Directed addresses 0 and all-ones confirm that the shifters start and end cleanly and do not leak bits between transactions. A write with the select bit low tells the one-hot decode apart from any-write triggering. A write during a transfer separates "ignored" from "restarted" or "queued", and a read in the middle of a transfer separates a held word from a live shift register. A reset in mid-transfer shows that the outputs abort at once.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   localparam logic [7:0] SFR_READ_OP    = 8'h03;
   localparam int         SFR_WORD_BYTES = 4;
   localparam int         SFR_WORD_BITS  = 8 * SFR_WORD_BYTES;

   // First received byte sits in the top of the shift register; move it to the bottom.
   function automatic logic [SFR_WORD_BITS-1:0] sfr_byte_swap(input logic [SFR_WORD_BITS-1:0] v);
      logic [SFR_WORD_BITS-1:0] r;
      for (int b = 0; b < SFR_WORD_BYTES; b++) begin
         r[8*b +: 8] = v[8*(SFR_WORD_BYTES-1-b) +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
   parameter int DIV_HALF = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);

   if (DIV_HALF < 1) begin : g_bad_div
      $error("sfr_tick: DIV_HALF must be at least 1");
   end

   if (DIV_HALF == 1) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst || !run) begin
            cnt_q <= '0;
         end else if (cnt_q == TOP) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick = run && (cnt_q == TOP);

      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
         tick |=> !tick);
   end

endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
   import sfr_pkg::*;
#(
   parameter int FADDR_W = 24
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [FADDR_W-1:0]       addr,
   input  logic                     tick,
   input  logic                     miso,
   output logic                     sck,
   output logic                     cs_n,
   output logic                     mosi,
   output logic                     busy,
   output logic                     finish,
   output logic [SFR_WORD_BITS-1:0] rx
);

   localparam int OUT_BITS   = 8 + FADDR_W;
   localparam int TOTAL_HALF = 2 * (OUT_BITS + SFR_WORD_BITS);
   localparam int HC_W       = $clog2(TOTAL_HALF + 1);
   localparam logic [HC_W-1:0] LAST_H  = HC_W'(TOTAL_HALF);
   localparam logic [HC_W-1:0] RX_FROM = HC_W'(2 * OUT_BITS);

   if (FADDR_W < 8 || FADDR_W > 32 || (FADDR_W % 8) != 0) begin : g_bad_faddr
      $error("sfr_seq: FADDR_W must be 8, 16, 24 or 32");
   end

   logic [OUT_BITS-1:0] out_sr;
   logic [HC_W-1:0]     hcnt;

   assign finish = busy && tick && (hcnt == LAST_H);
   assign mosi   = out_sr[OUT_BITS-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         cs_n   <= 1'b1;
         sck    <= 1'b0;
         out_sr <= '0;
         rx     <= '0;
         hcnt   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            cs_n   <= 1'b0;
            out_sr <= {SFR_READ_OP, addr};
            hcnt   <= '0;
         end
      end else if (tick) begin
         if (hcnt == LAST_H) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
         end else begin
            sck  <= ~sck;
            hcnt <= hcnt + 1'b1;
            if (!sck) begin
               if (hcnt >= RX_FROM) rx <= {rx[SFR_WORD_BITS-2:0], miso};
            end else begin
               out_sr <= {out_sr[OUT_BITS-2:0], 1'b0};
            end
         end
      end
   end

   // R4
   sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
      sck |-> !cs_n);

   // R4
   mosi_mode0_chk: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && $past(!cs_n) && !$fell(sck)) |-> $stable(mosi));

   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (cs_n && !sck));

endmodule

// File: rtl/sflash_word_reader.sv
module sflash_word_reader
   import sfr_pkg::*;
#(
   parameter int ADDR_BITS = 20,
   parameter int SEL_BIT   = 3,
   parameter int FADDR_W   = 24,
   parameter int DIV_HALF  = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 io_wstrb,
   input  logic [ADDR_BITS-1:0] io_word_addr,
   input  logic [31:0]          io_wdata,
   output logic [31:0]          io_rdata,
   output logic                 io_wbusy,
   output logic                 spi_sck,
   output logic                 spi_cs_n,
   output logic                 spi_mosi,
   input  logic                 spi_miso
);

   if (SEL_BIT < 0 || SEL_BIT >= ADDR_BITS) begin : g_bad_sel
      $error("sflash_word_reader: SEL_BIT outside the IO word address");
   end
   if (SFR_WORD_BITS != 32) begin : g_bad_word
      $error("sflash_word_reader: bus word must be 32 bits");
   end

   logic                     sel;
   logic                     tick;
   logic                     finish;
   logic [SFR_WORD_BITS-1:0] rx;
   logic [SFR_WORD_BITS-1:0] word_q;
   logic                     pins_unused;

   assign sel         = io_word_addr[SEL_BIT];
   assign pins_unused = ^{io_word_addr, io_wdata};

   sfr_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (io_wbusy),
      .tick (tick)
   );

   sfr_seq #(.FADDR_W(FADDR_W)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (io_wstrb && sel),
      .addr   (io_wdata[FADDR_W-1:0]),
      .tick   (tick),
      .miso   (spi_miso),
      .sck    (spi_sck),
      .cs_n   (spi_cs_n),
      .mosi   (spi_mosi),
      .busy   (io_wbusy),
      .finish (finish),
      .rx     (rx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
      end else if (finish) begin
         word_q <= sfr_byte_swap(rx);
      end
   end

   assign io_rdata = sel ? word_q : '0;

   // R9
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(word_q) |-> $fell(io_wbusy));

   // R2
   start_sel_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(io_wbusy) |-> $past(io_wstrb && sel));

   // R6
   cs_busy_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(spi_cs_n) |-> $fell(io_wbusy));

endmodule

// File: tb/sflash_word_reader_bench.sv
module sflash_word_reader_bench;

   localparam int PERIOD = 10;
   localparam int AB     = 20;
   localparam int SB     = 3;
   localparam int DIVH   = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          io_wstrb = 1'b0;
   logic [AB-1:0] io_word_addr = '0;
   logic [31:0]   io_wdata = '0;
   logic [31:0]   io_rdata;
   logic          io_wbusy;
   logic          spi_sck, spi_cs_n, spi_mosi;
   logic          spi_miso = 1'b0;

   int n_vec = 0;
   int n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   sflash_word_reader #(.ADDR_BITS(AB), .SEL_BIT(SB), .FADDR_W(24), .DIV_HALF(DIVH)) u_sflash_word_reader (
      .clk(clk), .rst(rst), .io_wstrb(io_wstrb), .io_word_addr(io_word_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_wbusy(io_wbusy),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      logic [31:0] t;
      t = {8'h0, a} * 32'd37 + {16'h0, a[23:8]} + 32'h5A;
      return t[7:0];
   endfunction

   function automatic logic [31:0] exp_word(input logic [23:0] a);
      return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // flash model and pin-timing monitor
   bit          mon_en = 1'b1;
   logic        prev_cs = 1'b1, prev_sck = 1'b0;
   int          rises = 0, since_cs = 0, since_fall = 0;
   logic [31:0] rx_cmd = '0;
   logic [31:0] dstream = '0;

   always @(negedge clk) begin
      if (!spi_cs_n && prev_cs) since_cs = 0; else since_cs++;
      if (!spi_sck && prev_sck) since_fall = 0; else since_fall++;
      if (!spi_cs_n && prev_cs) rises = 0;
      if (spi_sck && !prev_sck) begin
         if (rises == 0 && mon_en) chk(since_cs == DIVH, "R5 cs lead", since_cs, DIVH);
         if (rises < 32) rx_cmd = {rx_cmd[30:0], spi_mosi};
         rises++;
         if (rises == 32)
            dstream = {fbyte(rx_cmd[23:0]), fbyte(rx_cmd[23:0] + 24'd1),
                       fbyte(rx_cmd[23:0] + 24'd2), fbyte(rx_cmd[23:0] + 24'd3)};
      end
      if (!spi_sck && prev_sck && rises >= 32 && rises < 64) spi_miso = dstream[63 - rises];
      if (spi_cs_n && !prev_cs && mon_en) begin
         chk(rises == 64, "R5 pulse count", rises, 64);
         chk(since_fall == DIVH, "R5 cs tail", since_fall, DIVH);
      end
      prev_cs  = spi_cs_n;
      prev_sck = spi_sck;
   end

   task automatic bus_write(input bit sel, input logic [31:0] d);
      @(negedge clk);
      io_wstrb     = 1'b1;
      io_word_addr = AB'($urandom) & ~(AB'(1) << SB);
      if (sel) io_word_addr[SB] = 1'b1;
      io_wdata     = d;
      @(negedge clk);
      io_wstrb     = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (io_wbusy && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic read_word(input bit sel, output logic [31:0] v);
      io_word_addr = sel ? (AB'(1) << SB) : ~(AB'(1) << SB);
      #1 v = io_rdata;
   endtask

   task automatic fetch(input logic [31:0] d);
      int n;
      logic [31:0] v;
      bus_write(1'b1, d);
      wait_idle(n);
      chk(n == 129 * DIVH, "R6 busy length", n, 129 * DIVH);
      chk(spi_cs_n == 1'b1, "R6 cs high after", spi_cs_n, 1);
      chk(rx_cmd == {8'h03, d[23:0]}, "R3 command", rx_cmd, {8'h03, d[23:0]});
      read_word(1'b1, v);
      chk(v == exp_word(d[23:0]), "R7 word order", v, exp_word(d[23:0]));
      read_word(1'b0, v);
      chk(v == 32'h0, "R8 unselected zero", v, 0);
   endtask

   initial begin
      #(PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int unsigned s;
      int n;
      logic [31:0] v, wa;
      s = $urandom(32'h00C0FFEE);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
      chk(io_wbusy == 1'b0, "R1 busy", io_wbusy, 0);
      read_word(1'b1, v);
      chk(v == 32'h0, "R1 word cleared", v, 0);

      // R2 unselected write does nothing
      bus_write(1'b0, 32'h00123456);
      repeat (4) @(negedge clk);
      chk(io_wbusy == 1'b0, "R2 no start busy", io_wbusy, 0);
      chk(spi_cs_n == 1'b1, "R2 no start cs", spi_cs_n, 1);

      // directed corners
      fetch(32'h00000000);
      fetch(32'hFFFFFFFF);
      // random addresses, upper byte random
      for (int i = 0; i < 12; i++) fetch($urandom);

      // R9 write during busy ignored, held word stable mid-transfer
      wa = 32'hA5_13579B;
      fetch(wa);
      bus_write(1'b1, 32'h00_2468AC);
      repeat (30) @(negedge clk);
      read_word(1'b1, v);
      chk(v == exp_word(wa[23:0]), "R9 old word mid-transfer", v, exp_word(wa[23:0]));
      bus_write(1'b1, 32'h00_FEDCBA);
      wait_idle(n);
      chk(rx_cmd == {8'h03, 24'h2468AC}, "R9 address kept", rx_cmd, {8'h03, 24'h2468AC});
      read_word(1'b1, v);
      chk(v == exp_word(24'h2468AC), "R9 new word", v, exp_word(24'h2468AC));
      repeat (6) @(negedge clk);
      chk(io_wbusy == 1'b0, "R9 no second transfer", io_wbusy, 0);

      // R1 reset in mid-transfer
      bus_write(1'b1, 32'h00_0F0F0F);
      repeat (50) @(negedge clk);
      mon_en = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1 abort cs_n", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R1 abort sck", spi_sck, 0);
      chk(io_wbusy == 1'b0, "R1 abort busy", io_wbusy, 0);
      read_word(1'b1, v);
      chk(v == 32'h0, "R1 abort word", v, 0);
      rst = 1'b0;
      @(negedge clk);
      mon_en = 1'b1;
      fetch(32'h00_ABCDEF);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule